// File: doc/BRIEF.md
# Thermometer-Bead Lookahead Adder

This block adds two unsigned operands of width 4·n bits with a carry-in. It returns a 4·n-bit sum and a carry-out. It is purely combinational and has no registers. The operands are cut into 2-bit digits. Each digit is recoded as a three-bead thermometer holding a count from 0 to 3.

For each digit position, the two bead codes are merged by a selector network. The addend's bead code picks how far the augend's beads are shifted upward, and the result is a six-position thermometer holding the digit sum from 0 to 6. A fold stage turns that thermometer, plus the carry arriving at the digit, into two binary sum bits. The same thermometer provides the digit's carry terms directly:

- generate: the digit sum is at least 4;
- propagate: the digit sum is at least 3.

Two digits form a 4-bit unit, which resolves its internal carry by lookahead and reports group generate and propagate terms. A second lookahead level across the units gives the carry into each unit and the final carry-out.

Top module: `abacus_cla_adder`

## Requirements
- R1: A 2-bit digit (d1,d0) is recoded as the bead code {d1&d0, d1, d1|d0}, whose upper bits never exceed its lower ones. The bead code is a digit value of 0, 1, 2 or 3 given as 000, 001, 011 or 111.
- R2: Within each 4-bit unit, operand bits [1:0] form the low digit and bits [3:2] form the high digit. The carry out of the low digit feeds the high digit.
- R3: The merged digit thermometer K[5:0] is monotone (K[i] ≤ K[j] for i > j). Its count of ones equals the sum of the two bead counts.
- R4: A digit's two sum bits equal (ones(K) + incoming digit carry) mod 4.
- R5: A digit's carry-out is K[3] | (K[2] & incoming carry). Generate is therefore K[3] and propagate is K[2].
- R6: For every width, {carry_out, sum} equals a + b + carry_in as an unsigned (4n+1)-bit value. Carries cross 4-bit units through unit-level lookahead.
- R7: With n = 1, 9 + 13 and carry-in 0 gives sum 0110 and carry-out 1.
- R8: An all-ones operand plus zero with carry-in 1 carries through every digit and unit, giving sum 0 and carry-out 1.
- R9: Zero operands with carry-in 0 give sum 0 and carry-out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 4·UNITS | Augend |
| opb | input | 4·UNITS | Addend |
| cy_in | input | 1 | Carry into the least significant digit |
| total | output | 4·UNITS | Sum bits |
| cy_out | output | 1 | Carry out of the most significant unit |

## Verification
The bench goes after the edges of the thermometer merge.

- **Digit sums of 3 and 4.** A wrong generate or propagate tap would drop or invent a carry exactly there.
- **Carry-in meeting a digit sum of 3.** Only the propagate path can carry in this case. A design missing the AND with the incoming carry leaves the upper digits short by one.
- **Chains of propagating digits across unit boundaries.** Examples are all ones plus carry-in, and alternating patterns that sum to all ones. A broken second-level lookahead shows up as a wrong upper unit or a wrong carry-out.
- **Exhaustive run at n = 1.** This exposes a mis-shifted selector pattern or a fold bit taken from the wrong thermometer positions.

// File: rtl/abacus_pkg.sv
package abacus_pkg;
  localparam int BEADS = 3;
  localparam int TBITS = 2 * BEADS;

  typedef logic [BEADS-1:0] bead_t;
  typedef logic [TBITS-1:0] tsum_t;

  function automatic logic is_mono_bead(input bead_t v);
    return (v[2] <= v[1]) && (v[1] <= v[0]);
  endfunction

  function automatic logic is_mono_tsum(input tsum_t v);
    logic ok;
    ok = 1'b1;
    for (int i = 1; i < TBITS; i++) begin
      if (v[i] > v[i-1]) ok = 1'b0;
    end
    return ok;
  endfunction
endpackage

// File: rtl/abacus_digit_encode.sv
module abacus_digit_encode
  import abacus_pkg::*;
(
  input  logic [1:0] dig,
  output bead_t      bead
);
  always_comb begin
    bead[2] = dig[1] & dig[0];
    bead[1] = dig[1];
    bead[0] = dig[1] | dig[0];
  end
endmodule

// File: rtl/abacus_bead_merge.sv
module abacus_bead_merge
  import abacus_pkg::*;
(
  input  bead_t bead_y,
  input  bead_t bead_x,
  output tsum_t ktherm
);
  always_comb begin
    case (bead_x)
      3'b000:  ktherm = {3'b000, bead_y};
      3'b001:  ktherm = {2'b00, bead_y, 1'b1};
      3'b011:  ktherm = {1'b0, bead_y, 2'b11};
      3'b111:  ktherm = {bead_y, 3'b111};
      default: ktherm = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({bead_x, bead_y, ktherm})) begin
      // R1
      addend_mono_chk: assert (is_mono_bead(bead_x));
      // R1
      augend_mono_chk: assert (is_mono_bead(bead_y));
      // R3
      merge_count_chk: assert ($countones(ktherm) == $countones(bead_x) + $countones(bead_y));
    end
  end
endmodule

// File: rtl/abacus_digit_fold.sv
module abacus_digit_fold
  import abacus_pkg::*;
(
  input  tsum_t      ktherm,
  input  logic       dcy_in,
  output logic [1:0] dsum,
  output logic       dgen,
  output logic       dprop
);
  logic odd_cnt;
  logic cnt_b1;

  always_comb begin
    odd_cnt = ^ktherm;
    cnt_b1  = (ktherm[1] & ~ktherm[3]) | ktherm[5];
    dsum[0] = odd_cnt ^ dcy_in;
    dsum[1] = cnt_b1 ^ (odd_cnt & dcy_in);
    dgen    = ktherm[3];
    dprop   = ktherm[2];
  end

  always_comb begin
    if (!$isunknown(ktherm)) begin
      // R3
      ktherm_mono_chk: assert (is_mono_tsum(ktherm));
    end
  end
endmodule

// File: rtl/abacus_cla_unit.sv
module abacus_cla_unit
  import abacus_pkg::*;
(
  input  logic [3:0] ua,
  input  logic [3:0] ub,
  input  logic       ucy_in,
  output logic [3:0] usum,
  output logic       ugen,
  output logic       uprop
);
  localparam int NDIG = 2;

  logic [NDIG-1:0] dg;
  logic [NDIG-1:0] dp;
  logic [NDIG-1:0] dcy;

  always_comb begin
    dcy[0] = ucy_in;
    dcy[1] = dg[0] | (dp[0] & ucy_in);
    ugen   = dg[1] | (dp[1] & dg[0]);
    uprop  = dp[1] & dp[0];
  end

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    bead_t bead_a;
    bead_t bead_b;
    tsum_t kt;

    abacus_digit_encode u_enc_a (.dig(ua[2*d +: 2]), .bead(bead_a));
    abacus_digit_encode u_enc_b (.dig(ub[2*d +: 2]), .bead(bead_b));
    abacus_bead_merge   u_merge (.bead_y(bead_a), .bead_x(bead_b), .ktherm(kt));
    abacus_digit_fold   u_fold  (.ktherm(kt), .dcy_in(dcy[d]), .dsum(usum[2*d +: 2]),
                                 .dgen(dg[d]), .dprop(dp[d]));
  end
endmodule

// File: rtl/abacus_cla_adder.sv
module abacus_cla_adder #(
  parameter int UNITS = 2,
  localparam int W = 4 * UNITS
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cy_in,
  output logic [W-1:0] total,
  output logic         cy_out
);
  logic [UNITS-1:0] ug;
  logic [UNITS-1:0] up;
  logic [UNITS:0]   ucy;

  always_comb begin
    ucy[0] = cy_in;
    for (int u = 0; u < UNITS; u++) begin
      ucy[u+1] = ug[u] | (up[u] & ucy[u]);
    end
    cy_out = ucy[UNITS];
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    abacus_cla_unit u_unit (
      .ua    (opa[4*u +: 4]),
      .ub    (opb[4*u +: 4]),
      .ucy_in(ucy[u]),
      .usum  (total[4*u +: 4]),
      .ugen  (ug[u]),
      .uprop (up[u])
    );
  end

  always_comb begin
    if (!$isunknown({opa, opb, cy_in, total, cy_out})) begin
      // R6
      sum_match_chk: assert ({cy_out, total} == ({1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, cy_in}));
    end
  end
endmodule

// File: tb/abacus_cla_adder_bench.sv
module abacus_cla_adder_bench;
  localparam int NV = 10;
  // {a[7:0], b[7:0], cin, expected {cout,sum}[8:0]}
  localparam logic [25:0] VEC [NV] = '{
    {8'h00, 8'h00, 1'b0, 9'h000},
    {8'h09, 8'h0D, 1'b0, 9'h016},
    {8'hFF, 8'h00, 1'b1, 9'h100},
    {8'hFF, 8'hFF, 1'b1, 9'h1FF},
    {8'h0F, 8'h01, 1'b0, 9'h010},
    {8'h80, 8'h80, 1'b0, 9'h100},
    {8'h33, 8'h33, 1'b1, 9'h067},
    {8'hAA, 8'h55, 1'b1, 9'h100},
    {8'h7F, 8'h7F, 1'b0, 9'h0FE},
    {8'h3C, 8'hC3, 1'b0, 9'h0FF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0]  a2, b2;  logic c2;  logic [7:0]  s2;  logic co2;
  logic [3:0]  a1, b1;  logic c1;  logic [3:0]  s1;  logic co1;
  logic [31:0] a8, b8;  logic c8;  logic [31:0] s8;  logic co8;

  abacus_cla_adder #(.UNITS(2)) u_abacus_cla_adder (
    .opa(a2), .opb(b2), .cy_in(c2), .total(s2), .cy_out(co2));
  abacus_cla_adder #(.UNITS(1)) u_abacus_cla_adder_n1 (
    .opa(a1), .opb(b1), .cy_in(c1), .total(s1), .cy_out(co1));
  abacus_cla_adder #(.UNITS(8)) u_abacus_cla_adder_n8 (
    .opa(a8), .opb(b8), .cy_in(c8), .total(s8), .cy_out(co8));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic c);
    @(posedge clk);
    a1 = a[3:0]; b1 = b[3:0]; c1 = c;
    a2 = a[7:0]; b2 = b[7:0]; c2 = c;
    a8 = a;      b8 = b;      c8 = c;
    @(negedge clk);
  endtask

  task automatic check_wide(input string tag);
    logic [8:0]  e2;
    logic [32:0] e8;
    e2 = {1'b0, a2} + {1'b0, b2} + {8'd0, c2};
    e8 = {1'b0, a8} + {1'b0, b8} + {32'd0, c8};
    chk({co2, s2} == e2, {tag, " n=2"}, {55'd0, co2, s2}, {55'd0, e2});
    chk({co8, s8} == e8, {tag, " n=8"}, {31'd0, co8, s8}, {31'd0, e8});
  endtask

  initial begin
    a1 = '0; b1 = '0; c1 = 1'b0;
    a2 = '0; b2 = '0; c2 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R9: idle state with zero operands
    @(negedge clk);
    chk({co1, s1} == 5'd0, "R9 zero n=1", {59'd0, co1, s1}, 64'd0);
    chk({co2, s2} == 9'd0, "R9 zero n=2", {55'd0, co2, s2}, 64'd0);
    chk({co8, s8} == 33'd0, "R9 zero n=8", {31'd0, co8, s8}, 64'd0);

    // R6: vector table at n=2
    for (int i = 0; i < NV; i++) begin
      drive({24'd0, VEC[i][25:18]}, {24'd0, VEC[i][17:10]}, VEC[i][9]);
      chk({co2, s2} == VEC[i][8:0], "R6 table n=2", {55'd0, co2, s2}, {55'd0, VEC[i][8:0]});
    end

    // R7: 9 + 13 on one unit
    drive(32'd9, 32'd13, 1'b0);
    chk({co1, s1} == 5'b10110, "R7 9+13", {59'd0, co1, s1}, 64'h16);

    // R1: single digit values pass through recoding unchanged
    for (int d = 0; d < 4; d++) begin
      drive(32'(d), 32'd0, 1'b0);
      chk(s1 == 4'(d) && !co1, "R1 digit recode", {59'd0, co1, s1}, 64'(d));
    end

    // R2 R3 R4 R5 R6: exhaustive one-unit sweep
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < 2; c++) begin
          int lo, hi, clo;
          drive(32'(a), 32'(b), c[0]);
          lo  = (a % 4) + (b % 4) + c;
          clo = (lo >= 4) ? 1 : 0;
          hi  = (a / 4) + (b / 4) + clo;
          chk(s1[1:0] == 2'(lo % 4), "R4 low digit sum", {62'd0, s1[1:0]}, 64'(lo % 4));
          chk(s1[3:2] == 2'(hi % 4), "R2 high digit sum", {62'd0, s1[3:2]}, 64'(hi % 4));
          chk(co1 == (hi >= 4), "R5 digit carry", {63'd0, co1}, {63'd0, hi >= 4});
          chk({co1, s1} == 5'(a + b + c), "R3 R6 total n=1", {59'd0, co1, s1}, 64'(a + b + c));
        end
      end
    end

    // R8: carry through every digit
    drive(32'hFFFF_FFFF, 32'd0, 1'b1);
    chk({co1, s1} == 5'h10, "R8 ripple n=1", {59'd0, co1, s1}, 64'h10);
    chk({co2, s2} == 9'h100, "R8 ripple n=2", {55'd0, co2, s2}, 64'h100);
    chk({co8, s8} == 33'h1_0000_0000, "R8 ripple n=8", {31'd0, co8, s8}, 64'h1_0000_0000);
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
    check_wide("R8 alternating");
    drive(32'h3333_3333, 32'hCCCC_CCCC, 1'b0);
    check_wide("R6 no carry all-ones");

    // R6: random vectors
    for (int k = 0; k < 400; k++) begin
      drive($urandom, $urandom, 1'($urandom));
      check_wide("R6 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000 && !done) begin
        done = 1'b1;
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end
endmodule